// File: doc/BRIEF.md
# Auxiliary memory soft-switch mapper

This block holds the soft switches that steer an 8-bit computer's memory between its main and auxiliary banks, and that choose between internal ROM and peripheral-slot ROM in the 0xC1–0xCF page range. The CPU reaches the block through an I/O offset. A write to a switch offset turns one switch on or off. A read of a status offset returns the state of one switch in bit 7.

Given the 256-byte page number of the current access, the block produces three selects, all combinational. The first routes reads to auxiliary memory, the second routes writes to auxiliary memory, and the third makes the slot page read internal ROM. A display-store mode, together with a page-2 flag, overrides the general auxiliary selects for the text pages, and for the hi-res pages when hi-res mode is active. The block does not decode keyboard reads or video page selects. It raises a one-cycle forward strobe for each of them, so that the logic responsible can handle them. A down-counter driven by cycle enables times a vertical-blank window after each frame-start pulse.

Top module: `aux_mem_mapper`

## Requirements
- R1: A write access to offset k in 0x00–0x0B sets switch k>>1 when bit 0 of k is 1 and clears it when bit 0 is 0. Switch indices are 0 display-store, 1 aux-read, 2 aux-write, 3 internal-slot-ROM, 4 alternate-zero-page, 5 slot-3-ROM. The new value takes effect from the next clock edge.
- R2: A read access to any offset in 0x00–0x0B leaves every switch unchanged. A read of offset 0x00 raises kbd_fwd_o in the same cycle. A write to 0x00 does not raise it.
- R3: During a read access, stat_o returns 0x80 for a switch that is on and 0x00 for one that is off, at these offsets: 0x13 aux-read, 0x14 aux-write, 0x15 internal-slot-ROM, 0x16 alternate-zero-page, 0x17 slot-3-ROM, 0x18 display-store. At any other time stat_o is 0x00.
- R4: For pages 0x02–0xBF outside the display-store override, rd_aux_o follows aux-read and wr_aux_o follows aux-write, independently of each other. For pages 0xC0–0xFF both selects are 0.
- R5: When display-store is on, pages 0x04–0x07 drive both rd_aux_o and wr_aux_o to the page-2 flag, whatever aux-read and aux-write are.
- R6: Any access, read or write, to offset 0x54 clears page-2, and any access to 0x55 sets it. vid_fwd_o is raised for such an access only while display-store is off.
- R7: For pages 0x00–0x01, rd_aux_o and wr_aux_o both equal alternate-zero-page, whatever aux-read and aux-write are.
- R8: Pages 0x20–0x3F follow the page-2 flag, as in R5, only when display-store is on and hi_res_i is 1. Otherwise they follow R4.
- R9: int_rom_o is 1 for pages 0xC1–0xCF when internal-slot-ROM is on. When it is off, int_rom_o is 1 only for page 0xC3, and only while slot-3-ROM is off. For every other page int_rom_o is 0.
- R10: A read of status offset 0x19 returns 0x80 from the edge that samples frame_start_i until VBL_CYCLES further edges with cyc_en_i high, and 0x00 after that. Edges with cyc_en_i low do not shorten the window.
- R11: Reset clears all six switches, the page-2 flag and the blank window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Soft-switch access strobe |
| we_i | input | 1 | 1 = write access, 0 = read access |
| off_i | input | 8 | Soft-switch offset |
| page_i | input | 8 | Page number of the current memory access |
| hi_res_i | input | 1 | Hi-res graphics mode active |
| cyc_en_i | input | 1 | CPU cycle enable |
| frame_start_i | input | 1 | Start-of-blank pulse |
| rd_aux_o | output | 1 | Read from auxiliary memory |
| wr_aux_o | output | 1 | Write to auxiliary memory |
| int_rom_o | output | 1 | Slot page reads internal ROM |
| stat_o | output | 8 | Status read-back data |
| kbd_fwd_o | output | 1 | Forward this access to the keyboard logic |
| vid_fwd_o | output | 1 | Forward this access to the video logic |

## Verification
The assertions assume that acc_i, we_i and off_i are driven from register outputs, so that they are stable through each clock period. They also assume that page_i and hi_res_i are free inputs with no relation to the strobe. The properties about range and override therefore hold in every cycle, not only in cycles with an access. The stimulus changes every input on the falling edge and holds each access for exactly one rising edge. It samples the combinational selects and status a short delay later, within the same low phase. The blank-window assertion takes frame_start_i as a single-cycle pulse, and the bench drives it only that way.

// File: rtl/mmsw_pkg.sv
package mmsw_pkg;
  localparam int OFF_W  = 8;
  localparam int PAGE_W = 8;
  localparam int DATA_W = 8;

  // switch index = offset >> 1 for offsets 0x00..0x0B
  typedef enum logic [2:0] {
    SW_STORE = 3'd0,
    SW_AUXRD = 3'd1,
    SW_AUXWR = 3'd2,
    SW_INTCX = 3'd3,
    SW_ALTZP = 3'd4,
    SW_SLOT3 = 3'd5
  } sw_idx_e;

  localparam int NUM_SW = 6;
  localparam int SW_OFF_LAST = 2 * NUM_SW - 1;

  localparam logic [OFF_W-1:0] OFF_KBD   = 8'h00;
  localparam logic [OFF_W-1:0] OFF_STAT0 = 8'h13;
  localparam logic [OFF_W-1:0] OFF_VBL   = 8'h19;
  localparam logic [OFF_W-1:0] OFF_PG1   = 8'h54;
  localparam logic [OFF_W-1:0] OFF_PG2   = 8'h55;

  localparam logic [PAGE_W-1:0] PG_ZP_HI   = 8'h01;
  localparam logic [PAGE_W-1:0] PG_RAM_LO  = 8'h02;
  localparam logic [PAGE_W-1:0] PG_RAM_HI  = 8'hBF;
  localparam logic [PAGE_W-1:0] PG_TXT_LO  = 8'h04;
  localparam logic [PAGE_W-1:0] PG_TXT_HI  = 8'h07;
  localparam logic [PAGE_W-1:0] PG_HGR_LO  = 8'h20;
  localparam logic [PAGE_W-1:0] PG_HGR_HI  = 8'h3F;
  localparam logic [PAGE_W-1:0] PG_SLOT_LO = 8'hC1;
  localparam logic [PAGE_W-1:0] PG_SLOT_HI = 8'hCF;
  localparam logic [PAGE_W-1:0] PG_SLOT3   = 8'hC3;

  localparam logic [DATA_W-1:0] STAT_ON = 8'h80;
endpackage

// File: rtl/mmsw_switch_bank.sv
module mmsw_switch_bank
  import mmsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [NUM_SW-1:0] sw_o,
  output logic             page2_o
);
  localparam int IDX_W = OFF_W - 1;

  logic wr_acc;
  assign wr_acc = acc_i & we_i;

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    logic hit;
    assign hit = wr_acc && (off_i[OFF_W-1:1] == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  sw_o[g] <= 1'b0;
      else if (hit) sw_o[g] <= off_i[0];
    end
  end

  // page-2 responds to reads and writes alike
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           page2_o <= 1'b0;
    else if (acc_i && (off_i == OFF_PG1))  page2_o <= 1'b0;
    else if (acc_i && (off_i == OFF_PG2))  page2_o <= 1'b1;
  end
endmodule

// File: rtl/mmsw_page_map.sv
module mmsw_page_map
  import mmsw_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  logic              hi_res_i,
  input  logic [NUM_SW-1:0] sw_i,
  input  logic              page2_i,
  output logic              rd_aux_o,
  output logic              wr_aux_o,
  output logic              int_rom_o
);
  logic in_zp, in_ram, in_txt, in_hgr, in_slot, is_slot3, store_ovr;

  assign in_zp    = page_i <= PG_ZP_HI;
  assign in_ram   = (page_i >= PG_RAM_LO) && (page_i <= PG_RAM_HI);
  assign in_txt   = (page_i >= PG_TXT_LO) && (page_i <= PG_TXT_HI);
  assign in_hgr   = (page_i >= PG_HGR_LO) && (page_i <= PG_HGR_HI);
  assign in_slot  = (page_i >= PG_SLOT_LO) && (page_i <= PG_SLOT_HI);
  assign is_slot3 = page_i == PG_SLOT3;

  assign store_ovr = sw_i[SW_STORE] && (in_txt || (hi_res_i && in_hgr));

  always_comb begin
    rd_aux_o = 1'b0;
    wr_aux_o = 1'b0;
    if (in_zp) begin
      rd_aux_o = sw_i[SW_ALTZP];
      wr_aux_o = sw_i[SW_ALTZP];
    end else if (store_ovr) begin
      rd_aux_o = page2_i;
      wr_aux_o = page2_i;
    end else if (in_ram) begin
      rd_aux_o = sw_i[SW_AUXRD];
      wr_aux_o = sw_i[SW_AUXWR];
    end
  end

  always_comb begin
    if (!in_slot)            int_rom_o = 1'b0;
    else if (sw_i[SW_INTCX]) int_rom_o = 1'b1;
    else                     int_rom_o = is_slot3 && !sw_i[SW_SLOT3];
  end
endmodule

// File: rtl/mmsw_vbl_timer.sv
module mmsw_vbl_timer #(
  parameter int VBL_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic cyc_en_i,
  output logic vbl_o
);
  localparam int CNT_W = $clog2(VBL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(VBL_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (frame_start_i)               cnt_q <= CNT_LOAD;
    else if (cyc_en_i && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
  end

  assign vbl_o = cnt_q != '0;
endmodule

// File: rtl/mmsw_status_mux.sv
module mmsw_status_mux
  import mmsw_pkg::*;
(
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [NUM_SW-1:0] sw_i,
  input  logic              vbl_i,
  output logic [DATA_W-1:0] stat_o
);
  // status slot k reports switch (k+1) mod NUM_SW; display-store comes last
  logic [NUM_SW-1:0] hit;
  for (genvar k = 0; k < NUM_SW; k++) begin : g_stat
    assign hit[k] = (off_i == OFF_STAT0 + OFF_W'(k)) && sw_i[(k + 1) % NUM_SW];
  end

  logic bit_on;
  assign bit_on = (|hit) || ((off_i == OFF_VBL) && vbl_i);

  assign stat_o = (acc_i && !we_i && bit_on) ? STAT_ON : '0;
endmodule

// File: rtl/aux_mem_mapper.sv
module aux_mem_mapper
  import mmsw_pkg::*;
#(
  parameter int VBL_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              hi_res_i,
  input  logic              cyc_en_i,
  input  logic              frame_start_i,
  output logic              rd_aux_o,
  output logic              wr_aux_o,
  output logic              int_rom_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              kbd_fwd_o,
  output logic              vid_fwd_o
);
  logic [NUM_SW-1:0] sw_q;
  logic              page2_q;
  logic              vbl_q;

  mmsw_switch_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc_i),
    .we_i    (we_i),
    .off_i   (off_i),
    .sw_o    (sw_q),
    .page2_o (page2_q)
  );

  mmsw_page_map u_map (
    .page_i    (page_i),
    .hi_res_i  (hi_res_i),
    .sw_i      (sw_q),
    .page2_i   (page2_q),
    .rd_aux_o  (rd_aux_o),
    .wr_aux_o  (wr_aux_o),
    .int_rom_o (int_rom_o)
  );

  mmsw_vbl_timer #(.VBL_CYCLES(VBL_CYCLES)) u_vbl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .cyc_en_i      (cyc_en_i),
    .vbl_o         (vbl_q)
  );

  mmsw_status_mux u_stat (
    .acc_i  (acc_i),
    .we_i   (we_i),
    .off_i  (off_i),
    .sw_i   (sw_q),
    .vbl_i  (vbl_q),
    .stat_o (stat_o)
  );

  assign kbd_fwd_o = acc_i && !we_i && (off_i == OFF_KBD);
  assign vid_fwd_o = acc_i && !sw_q[SW_STORE] &&
                     ((off_i == OFF_PG1) || (off_i == OFF_PG2));
endmodule

// File: rtl/mmsw_checker.sv
module mmsw_checker
  import mmsw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic              we_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [PAGE_W-1:0] page_i,
  input logic              frame_start_i,
  input logic              rd_aux_o,
  input logic              wr_aux_o,
  input logic              int_rom_o,
  input logic [DATA_W-1:0] stat_o,
  input logic              kbd_fwd_o,
  input logic              vid_fwd_o,
  input logic [NUM_SW-1:0] sw_q,
  input logic              page2_q,
  input logic              vbl_q
);
  AST_WR_SETS_AUXRD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i && off_i == 8'h03) |=> sw_q[SW_AUXRD]); // R1
  AST_RD_KEEPS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && off_i <= 8'h0B) |=> $stable(sw_q)); // R2
  AST_KBD_FWD_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_fwd_o |-> (acc_i && !we_i && off_i == 8'h00)); // R2
  AST_STAT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && !we_i) |-> stat_o == 8'h00); // R3
  AST_TEXT_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q[SW_STORE] && page_i >= 8'h04 && page_i <= 8'h07) |->
      (rd_aux_o == page2_q && wr_aux_o == page2_q)); // R5
  AST_VID_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_fwd_o |-> (acc_i && !sw_q[SW_STORE] && (off_i == 8'h54 || off_i == 8'h55))); // R6
  AST_ZP_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_i <= 8'h01) |-> (rd_aux_o == sw_q[SW_ALTZP] && wr_aux_o == sw_q[SW_ALTZP])); // R7
  AST_INTROM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rom_o |-> (page_i >= 8'hC1 && page_i <= 8'hCF)); // R9
  AST_VBL_ONSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vbl_q) |-> $past(frame_start_i)); // R10
endmodule

bind aux_mem_mapper mmsw_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_i         (acc_i),
  .we_i          (we_i),
  .off_i         (off_i),
  .page_i        (page_i),
  .frame_start_i (frame_start_i),
  .rd_aux_o      (rd_aux_o),
  .wr_aux_o      (wr_aux_o),
  .int_rom_o     (int_rom_o),
  .stat_o        (stat_o),
  .kbd_fwd_o     (kbd_fwd_o),
  .vid_fwd_o     (vid_fwd_o),
  .sw_q          (sw_q),
  .page2_q       (page2_q),
  .vbl_q         (vbl_q)
);

// File: tb/tb_aux_mem_mapper.sv
`timescale 1ns/1ps
module tb_aux_mem_mapper;
  localparam int VBL = 1000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_i = 1'b0, we_i = 1'b0;
  logic [7:0] off_i = 8'h00, page_i = 8'h00;
  logic       hi_res_i = 1'b0, cyc_en_i = 1'b0, frame_start_i = 1'b0;
  logic       rd_aux_o, wr_aux_o, int_rom_o, kbd_fwd_o, vid_fwd_o;
  logic [7:0] stat_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  aux_mem_mapper #(.VBL_CYCLES(VBL)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] off);
    @(negedge clk_i);
    acc_i = 1'b1; we_i = we; off_i = off;
    @(negedge clk_i);
    acc_i = 1'b0; we_i = 1'b0; off_i = 8'h00;
  endtask

  // combinational status peek, no clock edge consumed
  task automatic peek(input logic [7:0] off, output logic [7:0] v);
    acc_i = 1'b1; we_i = 1'b0; off_i = off;
    #0.5 v = stat_o;
    acc_i = 1'b0; off_i = 8'h00;
    #0.1;
  endtask

  task automatic map(input string tag, input logic [7:0] pg, input logic hr,
                     input logic erd, input logic ewr);
    page_i = pg; hi_res_i = hr;
    #0.5;
    chk(tag, {rd_aux_o, wr_aux_o}, {erd, ewr});
  endtask

  task automatic rom(input string tag, input logic [7:0] pg, input logic exp);
    page_i = pg;
    #0.5;
    chk(tag, int_rom_o, exp);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int k = 8'h13; k <= 8'h19; k++) begin
      peek(8'(k), v);
      chk("R11 status after reset", v, 0);
    end
    map("R11 page 0x60 main", 8'h60, 1'b0, 1'b0, 1'b0);
    map("R11 page 0x00 main", 8'h00, 1'b0, 1'b0, 1'b0);
    rom("R11 C3 internal", 8'hC3, 1'b1);
  endtask

  task automatic t_switches;
    logic [7:0] v;
    // offset->switch index: off>>1; status offset per index
    logic [7:0] stat_of [6] = '{8'h18, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
    for (int i = 0; i < 6; i++) begin
      access(1'b1, 8'(2 * i + 1));
      peek(stat_of[i], v);
      chk("R1/R3 switch on", v, 8'h80);
      access(1'b1, 8'(2 * i));
      peek(stat_of[i], v);
      chk("R1/R3 switch off", v, 8'h00);
    end
    peek(8'h20, v);
    chk("R3 unrelated offset", v, 0);
  endtask

  task automatic t_read_ignored;
    logic [7:0] v;
    access(1'b0, 8'h03);
    peek(8'h13, v);
    chk("R2 read of 0x03 ignored", v, 0);
    access(1'b0, 8'h09);
    map("R2 read of 0x09 ignored", 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    acc_i = 1'b1; we_i = 1'b0; off_i = 8'h00; #0.5;
    chk("R2 kbd forward on read", kbd_fwd_o, 1);
    we_i = 1'b1; #0.5;
    chk("R2 no kbd forward on write", kbd_fwd_o, 0);
    @(negedge clk_i);
    acc_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic t_aux_rw;
    access(1'b1, 8'h03);                 // aux read on
    map("R4 aux read only", 8'h60, 1'b0, 1'b1, 1'b0);
    map("R4 page 0x02", 8'h02, 1'b0, 1'b1, 1'b0);
    map("R4 page 0xC0 main", 8'hC0, 1'b0, 1'b0, 1'b0);
    map("R7 zp unaffected by aux read", 8'h01, 1'b0, 1'b0, 1'b0);
    access(1'b1, 8'h02); access(1'b1, 8'h05);  // read off, write on
    map("R4 aux write only", 8'hBF, 1'b0, 1'b0, 1'b1);
    access(1'b1, 8'h04);
  endtask

  task automatic t_store;
    access(1'b1, 8'h03); access(1'b1, 8'h05);  // aux rd+wr on
    access(1'b1, 8'h01);                       // display-store on
    map("R5 text page2 clear", 8'h05, 1'b0, 1'b0, 1'b0);
    map("R8 hires off follows aux", 8'h30, 1'b0, 1'b1, 1'b1);
    map("R8 hires on page2 clear", 8'h30, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    acc_i = 1'b1; we_i = 1'b0; off_i = 8'h55; #0.5;
    chk("R6 no video forward when store on", vid_fwd_o, 0);
    @(negedge clk_i);
    acc_i = 1'b0; off_i = 8'h00;
    map("R5/R6 text page2 set by read", 8'h07, 1'b0, 1'b1, 1'b1);
    access(1'b1, 8'h02); access(1'b1, 8'h04);  // aux off
    map("R5 override beats aux off", 8'h04, 1'b0, 1'b1, 1'b1);
    map("R8 hires on page2 set", 8'h20, 1'b1, 1'b1, 1'b1);
    map("R4 non-display page main", 8'h40, 1'b1, 1'b0, 1'b0);
    access(1'b1, 8'h00);                       // store off
    map("R5 store off uses aux sel", 8'h04, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    acc_i = 1'b1; we_i = 1'b1; off_i = 8'h54; #0.5;
    chk("R6 video forward when store off", vid_fwd_o, 1);
    @(negedge clk_i);
    acc_i = 1'b0; we_i = 1'b0; off_i = 8'h00;
    access(1'b1, 8'h01);
    map("R6 page2 cleared by 0x54", 8'h04, 1'b0, 1'b0, 1'b0);
    access(1'b1, 8'h00);
  endtask

  task automatic t_altzp;
    access(1'b1, 8'h09);
    map("R7 altzp page 0", 8'h00, 1'b0, 1'b1, 1'b1);
    map("R7 altzp page 1", 8'h01, 1'b0, 1'b1, 1'b1);
    map("R7 altzp not page 2", 8'h02, 1'b0, 1'b0, 1'b0);
    access(1'b1, 8'h08);
  endtask

  task automatic t_rom;
    rom("R9 C1 slot", 8'hC1, 1'b0);
    access(1'b1, 8'h0B);
    rom("R9 C3 slot when slot3 on", 8'hC3, 1'b0);
    access(1'b1, 8'h07);
    rom("R9 C1 internal", 8'hC1, 1'b1);
    rom("R9 CF internal", 8'hCF, 1'b1);
    rom("R9 C3 internal when intcx on", 8'hC3, 1'b1);
    rom("R9 D0 never", 8'hD0, 1'b0);
    rom("R9 C0 never", 8'hC0, 1'b0);
    access(1'b1, 8'h06); access(1'b1, 8'h0A);
  endtask

  task automatic t_vbl;
    logic [7:0] v;
    @(negedge clk_i);
    frame_start_i = 1'b1; cyc_en_i = 1'b0;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    repeat (5) @(negedge clk_i);       // stalled edges
    peek(8'h19, v);
    chk("R10 window open", v, 8'h80);
    cyc_en_i = 1'b1;
    repeat (VBL - 1) @(negedge clk_i);
    peek(8'h19, v);
    chk("R10 last window cycle", v, 8'h80);
    @(negedge clk_i);
    peek(8'h19, v);
    chk("R10 window closed", v, 8'h00);
    @(negedge clk_i);
    frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    access(1'b1, 8'h09); access(1'b1, 8'h01);
    rst_ni = 1'b0; #1; rst_ni = 1'b1;
    peek(8'h19, v);
    chk("R11 reset clears window", v, 0);
    peek(8'h16, v);
    chk("R11 reset clears altzp", v, 0);
    peek(8'h18, v);
    chk("R11 reset clears store", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_switches();
    t_read_ignored();
    t_aux_rw();
    t_store();
    t_altzp();
    t_rom();
    t_vbl();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule